// File: doc/BRIEF.md
# Software-Loaded Translation Buffer Lookup

This block is the lookup half of a translation buffer for a 32-bit MMU whose page tables are hashed and whose buffer entries are written by software. A request carries an effective address, an access kind (instruction fetch, data load or data store), a 30-bit compare tag (segment identifier followed by the abbreviated page index), a protection key and a no-execute flag. Every way is probed at the set chosen by the address, with a separate group of sets for instruction and data accesses. The block returns, one clock later, a status (miss, granted or denied), a read/write/execute permission set and a real address.

A lookup that hits also maintains the referenced and changed bits of the chosen entry. When the changed bit is still clear and the access is not a granted store, write permission is taken out of the returned set. A store made under that returned set therefore faults the first time, and software can then mark the page dirty. A miss writes the compare tag into an instruction or data miss-compare register, so the refill handler can use it. Software loads entries through a plain write port and reads back the second entry word through a read port, to collect the referenced and changed bits.

Top module: `swtlb_lookup`

## Requirements
- R1: After reset, rs_valid is 0, both miss-compare registers read 0 and every entry is invalid.
- R2: A way is a candidate only if its stored page number equals lk_ea[31:12], word0 bit 31 (valid) is 1, word0 bit 6 (hash select) is 0, and {word0[30:7], word0[5:0]} equals lk_tag. No candidate means status miss (2'b00).
- R3: The set index is lk_ea[16:12]. Instruction fetches (lk_acc=2'b00) use one group of sets and loads (2'b01) and stores (2'b10) use another. The write and read ports choose the group with their code select (1 = instruction).
- R4: Permissions come from word1[1:0] (PP) and the key, as rs_perm = {exec, write, read}. With key 0, PP 0 to 2 give read-write and PP 3 gives read-only. With key 1, PP 0 gives none, PP 1 and 3 give read-only and PP 2 gives read-write. Execute equals read unless lk_nx is set. A fetch needs execute, a load needs read and a store needs write; a hit that meets the need is granted (2'b01), otherwise denied (2'b10).
- R5: Ways are scanned from way 0 upward, and the scan stops at the first granted candidate, so later ways are neither chosen nor updated.
- R6: A denied candidate does not stop the scan. The last candidate accepted before the scan stops is the chosen entry.
- R7: A later candidate whose word1 real page number [31:12], WIMG [6:3] or PP [1:0] differ from those of the first accepted candidate is skipped.
- R8: Every hit, granted or denied, sets the referenced bit word1[8] of the chosen entry.
- R9: A granted store sets the changed bit word1[7]. If word1[7] is clear and the access is not a granted store, rs_perm[1] is forced to 0.
- R10: On a miss, {1'b0, lk_tag[29:6], 1'b0, lk_tag[5:0]} is written into imiss_cmp for a fetch or into dmiss_cmp otherwise. The other register keeps its value.
- R11: Results appear on the clock edge after a cycle with lk_valid high, with rs_valid high for exactly that one cycle.
- R12: rs_raddr is {word1[31:12] of the chosen entry, lk_ea[11:0]} on a hit. On a miss it is all ones and rs_perm is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software entry write strobe |
| wr_code | input | 1 | Write targets the instruction sets when 1 |
| wr_way | input | 1 | Way to write |
| wr_set | input | 5 | Set to write |
| wr_epn | input | 20 | Effective page number stored with the entry |
| wr_w0 | input | 32 | Entry word0 (valid, tag, hash select) |
| wr_w1 | input | 32 | Entry word1 (real page, R, C, WIMG, PP) |
| rd_code | input | 1 | Read-back targets the instruction sets when 1 |
| rd_way | input | 1 | Read-back way |
| rd_set | input | 5 | Read-back set |
| rd_w1 | output | 32 | Current word1 of the selected entry (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| lk_ea | input | 32 | Effective address |
| lk_tag | input | 30 | Compare tag |
| lk_key | input | 1 | Protection key |
| lk_nx | input | 1 | No-execute flag for the segment |
| rs_valid | output | 1 | Result strobe |
| rs_status | output | 2 | 00 miss, 01 granted, 10 denied |
| rs_perm | output | 3 | {exec, write, read} |
| rs_raddr | output | 32 | Real address, all ones on miss |
| imiss_cmp | output | 32 | Instruction miss-compare register |
| dmiss_cmp | output | 32 | Data miss-compare register |

## Verification
The bench sweeps every key, PP, access kind and no-execute combination with the changed bit preset, and it probes every set of both the instruction and data groups with distinct real pages. A mixed-up index or a missing code/data split would return the wrong page. Two-way cases put a denial in way 0 so that the scan must go on. It then checks whether a consistent second way takes the referenced-bit update and whether an inconsistent one that would grant is skipped. A design that stopped on denial, or that skipped no inconsistent entry, would flip the status or the updated way. Changed-bit cases show the write permission withheld on a clean page, restored after a granted store, and left alone by a denied store. Miss cases check the hit conditions one at a time and check that only the matching miss-compare register is written.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
   localparam logic [1:0] ACC_FETCH = 2'b00;
   localparam logic [1:0] ACC_LOAD  = 2'b01;
   localparam logic [1:0] ACC_STORE = 2'b10;

   localparam logic [1:0] ST_MISS  = 2'b00;
   localparam logic [1:0] ST_GRANT = 2'b01;
   localparam logic [1:0] ST_DENY  = 2'b10;

   localparam int W0_VALID = 31;
   localparam int W0_HSEL  = 6;
   localparam int W1_REF   = 8;
   localparam int W1_CHG   = 7;
   localparam logic [31:0] W1_CONS_MASK = 32'hFFFF_F07B;

   // perm = {exec, write, read}
   function automatic logic [2:0] perm_of(input logic key, input logic [1:0] pp,
                                          input logic nx);
      logic rd, wr;
      if (!key) begin
         rd = 1'b1;
         wr = (pp != 2'b11);
      end else begin
         rd = (pp != 2'b00);
         wr = (pp == 2'b10);
      end
      return {rd & ~nx, wr, rd};
   endfunction

   function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
      case (acc)
         ACC_FETCH: return perm[2];
         ACC_STORE: return perm[1];
         default:   return perm[0];
      endcase
   endfunction
endpackage

// File: rtl/swtlb_bank.sv
module swtlb_bank #(
   parameter int SET_BITS = 5,
   parameter int EPN_W    = 20,
   localparam int IDX_W   = SET_BITS + 1,
   localparam int ENTRIES = 2 << SET_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [EPN_W-1:0] wr_epn,
   input  logic [31:0]      wr_w0,
   input  logic [31:0]      wr_w1,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_chg,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [EPN_W-1:0] lk_epn,
   output logic [31:0]      lk_w0,
   output logic [31:0]      lk_w1,
   input  logic [IDX_W-1:0] sw_idx,
   output logic [31:0]      sw_w1
);
   import swtlb_pkg::*;

   logic [EPN_W-1:0] epn_q [ENTRIES];
   logic [31:0]      w0_q  [ENTRIES];
   logic [31:0]      w1_q  [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            epn_q[i] <= '0;
            w0_q[i]  <= '0;
            w1_q[i]  <= '0;
         end
      end else begin
         if (upd_en) begin
            w1_q[upd_idx][W1_REF] <= 1'b1;
            if (upd_chg) w1_q[upd_idx][W1_CHG] <= 1'b1;
         end
         if (wr_en) begin
            epn_q[wr_idx] <= wr_epn;
            w0_q[wr_idx]  <= wr_w0;
            w1_q[wr_idx]  <= wr_w1;
         end
      end
   end

   assign lk_epn = epn_q[lk_idx];
   assign lk_w0  = w0_q[lk_idx];
   assign lk_w1  = w1_q[lk_idx];
   assign sw_w1  = w1_q[sw_idx];

   // R8: an update leaves the referenced bit set unless software overwrote it
   assert_ref_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en && !(wr_en && wr_idx == upd_idx) |=> w1_q[$past(upd_idx)][W1_REF]);
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match #(
   parameter int EPN_W = 20
) (
   input  logic [EPN_W-1:0] ent_epn,
   input  logic [31:0]      ent_w0,
   input  logic [31:0]      ent_w1,
   input  logic [EPN_W-1:0] req_page,
   input  logic [29:0]      req_tag,
   input  logic [1:0]       req_acc,
   input  logic             req_key,
   input  logic             req_nx,
   output logic             cand,
   output logic             allow,
   output logic [2:0]       perm,
   output logic [31:0]      cons
);
   import swtlb_pkg::*;

   logic [29:0] ent_tag;
   assign ent_tag = {ent_w0[30:7], ent_w0[5:0]};
   assign cand  = ent_w0[W0_VALID] && !ent_w0[W0_HSEL] &&
                  (ent_epn == req_page) && (ent_tag == req_tag);
   assign perm  = perm_of(req_key, ent_w1[1:0], req_nx);
   assign allow = perm_allows(perm, req_acc);
   assign cons  = ent_w1 & W1_CONS_MASK;
endmodule

// File: rtl/swtlb_select.sv
module swtlb_select #(
   parameter int WAYS  = 2,
   localparam int WB   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]       cand,
   input  logic [WAYS-1:0]       allow,
   input  logic [WAYS-1:0][31:0] cons,
   output logic                  hit,
   output logic                  grant,
   output logic [WB-1:0]         best
);
   logic        stop;
   logic [31:0] first;

   always_comb begin
      hit   = 1'b0;
      grant = 1'b0;
      stop  = 1'b0;
      best  = '0;
      first = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!stop && cand[w] && (!hit || cons[w] == first)) begin
            if (!hit) first = cons[w];
            hit   = 1'b1;
            best  = WB'(w);
            grant = allow[w];
            stop  = allow[w];
         end
      end
   end
endmodule

// File: rtl/swtlb_lookup.sv
module swtlb_lookup #(
   parameter int WAYS     = 2,
   parameter int SET_BITS = 5,
   parameter int IDX_LSB  = 12,
   localparam int WB      = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int EPN_W   = 20,
   localparam int IDX_W   = SET_BITS + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_code,
   input  logic [WB-1:0]       wr_way,
   input  logic [SET_BITS-1:0] wr_set,
   input  logic [EPN_W-1:0]    wr_epn,
   input  logic [31:0]         wr_w0,
   input  logic [31:0]         wr_w1,
   input  logic                rd_code,
   input  logic [WB-1:0]       rd_way,
   input  logic [SET_BITS-1:0] rd_set,
   output logic [31:0]         rd_w1,
   input  logic                lk_valid,
   input  logic [1:0]          lk_acc,
   input  logic [31:0]         lk_ea,
   input  logic [29:0]         lk_tag,
   input  logic                lk_key,
   input  logic                lk_nx,
   output logic                rs_valid,
   output logic [1:0]          rs_status,
   output logic [2:0]          rs_perm,
   output logic [31:0]         rs_raddr,
   output logic [31:0]         imiss_cmp,
   output logic [31:0]         dmiss_cmp
);
   import swtlb_pkg::*;

   initial begin
      assert (WAYS >= 1 && WAYS <= 16) else $error("WAYS out of range");
      assert (IDX_LSB >= 12 && IDX_LSB + SET_BITS <= 32) else $error("index field out of range");
   end

   logic                  is_code;
   logic [IDX_W-1:0]      lk_idx, wr_idx, sw_idx;
   logic [EPN_W-1:0]      page;
   logic [WAYS-1:0]       cand, allow;
   logic [WAYS-1:0][2:0]  perm_w;
   logic [WAYS-1:0][31:0] cons_w, w1_w, sw_w;
   logic                  hit, grant;
   logic [WB-1:0]         best;
   logic                  is_store, store_ok;
   logic [19:0]           best_rpn;
   logic                  best_chg;
   logic [2:0]            perm_out;

   assign is_code  = (lk_acc == ACC_FETCH);
   assign lk_idx   = {is_code, lk_ea[IDX_LSB +: SET_BITS]};
   assign wr_idx   = {wr_code, wr_set};
   assign sw_idx   = {rd_code, rd_set};
   assign page     = lk_ea[31:12];
   assign is_store = (lk_acc == ACC_STORE);
   assign store_ok = is_store && grant;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [EPN_W-1:0] e_epn;
      logic [31:0]      e_w0;
      logic             upd;

      assign upd = lk_valid && hit && (best == WB'(w));

      swtlb_bank #(.SET_BITS(SET_BITS), .EPN_W(EPN_W)) bank_i (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_en && wr_way == WB'(w)), .wr_idx(wr_idx),
         .wr_epn(wr_epn), .wr_w0(wr_w0), .wr_w1(wr_w1),
         .upd_en(upd), .upd_idx(lk_idx), .upd_chg(store_ok),
         .lk_idx(lk_idx), .lk_epn(e_epn), .lk_w0(e_w0), .lk_w1(w1_w[w]),
         .sw_idx(sw_idx), .sw_w1(sw_w[w])
      );

      swtlb_match #(.EPN_W(EPN_W)) match_i (
         .ent_epn(e_epn), .ent_w0(e_w0), .ent_w1(w1_w[w]),
         .req_page(page), .req_tag(lk_tag), .req_acc(lk_acc),
         .req_key(lk_key), .req_nx(lk_nx),
         .cand(cand[w]), .allow(allow[w]), .perm(perm_w[w]), .cons(cons_w[w])
      );
   end

   swtlb_select #(.WAYS(WAYS)) select_i (
      .cand(cand), .allow(allow), .cons(cons_w),
      .hit(hit), .grant(grant), .best(best)
   );

   assign rd_w1    = sw_w[rd_way];
   assign best_rpn = w1_w[best][31:12];
   assign best_chg = w1_w[best][W1_CHG];
   assign perm_out = perm_w[best] & ((!best_chg && !store_ok) ? 3'b101 : 3'b111);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid  <= 1'b0;
         rs_status <= ST_MISS;
         rs_perm   <= '0;
         rs_raddr  <= '1;
         imiss_cmp <= '0;
         dmiss_cmp <= '0;
      end else begin
         rs_valid <= lk_valid;
         if (lk_valid) begin
            if (hit) begin
               rs_status <= grant ? ST_GRANT : ST_DENY;
               rs_perm   <= perm_out;
               rs_raddr  <= {best_rpn, lk_ea[11:0]};
            end else begin
               rs_status <= ST_MISS;
               rs_perm   <= '0;
               rs_raddr  <= '1;
               if (is_code) imiss_cmp <= {1'b0, lk_tag[29:6], 1'b0, lk_tag[5:0]};
               else         dmiss_cmp <= {1'b0, lk_tag[29:6], 1'b0, lk_tag[5:0]};
            end
         end
      end
   end

   assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);
   assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid);
   assert_status_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> rs_status != 2'b11);
   assert_miss_raddr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && rs_status == ST_MISS |-> rs_raddr == '1 && rs_perm == 3'b000);
   assert_grant_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> hit);
   assert_store_keeps_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && is_store && grant |=> rs_perm[1]);
   assert_denied_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && hit && !grant && is_code |=> !rs_perm[2]);
   assert_imiss_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && is_code && !hit |=>
         imiss_cmp == {1'b0, $past(lk_tag[29:6]), 1'b0, $past(lk_tag[5:0])});
   assert_dmiss_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && is_code |=> $stable(dmiss_cmp));
endmodule

// File: tb/swtlb_lookup_tb_top.sv
module swtlb_lookup_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_code = 1'b0;
   logic [0:0]  wr_way = '0;
   logic [4:0]  wr_set = '0;
   logic [19:0] wr_epn = '0;
   logic [31:0] wr_w0 = '0, wr_w1 = '0;
   logic        rd_code = 1'b0;
   logic [0:0]  rd_way = '0;
   logic [4:0]  rd_set = '0;
   logic [31:0] rd_w1;
   logic        lk_valid = 1'b0;
   logic [1:0]  lk_acc = '0;
   logic [31:0] lk_ea = '0;
   logic [29:0] lk_tag = '0;
   logic        lk_key = 1'b0, lk_nx = 1'b0;
   logic        rs_valid;
   logic [1:0]  rs_status;
   logic [2:0]  rs_perm;
   logic [31:0] rs_raddr, imiss_cmp, dmiss_cmp;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   swtlb_lookup dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_code(wr_code), .wr_way(wr_way), .wr_set(wr_set),
      .wr_epn(wr_epn), .wr_w0(wr_w0), .wr_w1(wr_w1),
      .rd_code(rd_code), .rd_way(rd_way), .rd_set(rd_set), .rd_w1(rd_w1),
      .lk_valid(lk_valid), .lk_acc(lk_acc), .lk_ea(lk_ea), .lk_tag(lk_tag),
      .lk_key(lk_key), .lk_nx(lk_nx),
      .rs_valid(rs_valid), .rs_status(rs_status), .rs_perm(rs_perm),
      .rs_raddr(rs_raddr), .imiss_cmp(imiss_cmp), .dmiss_cmp(dmiss_cmp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_w0(input logic v, input logic h, input logic [29:0] t);
      return {v, t[29:6], h, t[5:0]};
   endfunction

   function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input logic r,
                                         input logic c, input logic [1:0] pp);
      return {rpn, 3'b000, r, c, 4'b0101, 1'b0, pp};
   endfunction

   function automatic logic [31:0] cmp_of(input logic [29:0] t);
      return {1'b0, t[29:6], 1'b0, t[5:0]};
   endfunction

   // expected {exec, write, read} from the permission table
   function automatic logic [2:0] exp_perm(input logic key, input logic [1:0] pp, input logic nx);
      logic r, w;
      if (key == 1'b0) begin r = 1'b1; w = (pp != 3); end
      else begin r = (pp != 0); w = (pp == 2); end
      return {r && !nx, w, r};
   endfunction

   function automatic logic exp_ok(input logic [2:0] p, input logic [1:0] acc);
      if (acc == 2'b00) return p[2];
      if (acc == 2'b10) return p[1];
      return p[0];
   endfunction

   task automatic put(input logic code, input logic way, input logic [4:0] set,
                      input logic [19:0] epn, input logic [31:0] w0, input logic [31:0] w1);
      @(negedge clk);
      wr_en = 1'b1; wr_code = code; wr_way = way; wr_set = set;
      wr_epn = epn; wr_w0 = w0; wr_w1 = w1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic look(input logic [1:0] acc, input logic [31:0] ea, input logic [29:0] t,
                       input logic key, input logic nx);
      @(negedge clk);
      lk_valid = 1'b1; lk_acc = acc; lk_ea = ea; lk_tag = t; lk_key = key; lk_nx = nx;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   function automatic logic [31:0] peek(input logic code, input logic way, input logic [4:0] set);
      rd_code = code; rd_way = way; rd_set = set;
      return 32'h0;
   endfunction

   task automatic rdw(input logic code, input logic way, input logic [4:0] set,
                      output logic [31:0] v);
      rd_code = code; rd_way = way; rd_set = set;
      #0.5;
      v = rd_w1;
   endtask

   localparam logic [29:0] T1 = 30'h0ABC_DE5;
   localparam logic [29:0] T2 = 30'h1234_567;
   localparam logic [29:0] T3 = 30'h2F0F_0F1;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, ea;
      logic [2:0]  p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rs_valid", {31'b0, rs_valid}, 32'h0);
      chk("R1 imiss", imiss_cmp, 32'h0);
      chk("R1 dmiss", dmiss_cmp, 32'h0);
      look(2'b01, 32'h1234_3A10, T1, 1'b0, 1'b0);
      chk("R1 empty lookup misses", {30'b0, rs_status}, 32'h0);

      // R4 sweep: key x PP x access x nx, changed bit preset
      for (int k = 0; k < 2; k++) begin
         for (int pp = 0; pp < 4; pp++) begin
            put(1'b0, 1'b0, 5'd3, 20'h12343, mk_w0(1, 0, T1), mk_w1(20'h0A0A0, 0, 1, pp[1:0]));
            put(1'b1, 1'b0, 5'd3, 20'h12343, mk_w0(1, 0, T1), mk_w1(20'h0B0B0, 0, 1, pp[1:0]));
            for (int a = 0; a < 3; a++) begin
               for (int nx = 0; nx < 2; nx++) begin
                  look(a[1:0], 32'h1234_3A10, T1, k[0], nx[0]);
                  p = exp_perm(k[0], pp[1:0], nx[0]);
                  chk("R11 strobe", {31'b0, rs_valid}, 32'h1);
                  chk("R4 status", {30'b0, rs_status},
                      exp_ok(p, a[1:0]) ? 32'h1 : 32'h2);
                  chk("R4 perm", {29'b0, rs_perm}, {29'b0, p});
                  chk("R12 raddr", rs_raddr,
                      {(a == 0) ? 20'h0B0B0 : 20'h0A0A0, 12'hA10});
               end
            end
         end
      end
      @(negedge clk);
      chk("R11 strobe drops", {31'b0, rs_valid}, 32'h0);

      // R2 candidate conditions, R10 miss-compare registers
      put(1'b0, 1'b0, 5'd5, 20'h00005, mk_w0(0, 0, T2), mk_w1(20'h00555, 0, 1, 2));
      look(2'b01, 32'h0000_5123, T2, 1'b0, 1'b0);
      chk("R2 invalid entry misses", {30'b0, rs_status}, 32'h0);
      chk("R12 miss raddr", rs_raddr, 32'hFFFF_FFFF);
      chk("R12 miss perm", {29'b0, rs_perm}, 32'h0);
      chk("R10 dmiss", dmiss_cmp, cmp_of(T2));
      put(1'b0, 1'b0, 5'd5, 20'h00005, mk_w0(1, 1, T2), mk_w1(20'h00555, 0, 1, 2));
      look(2'b01, 32'h0000_5123, T2, 1'b0, 1'b0);
      chk("R2 hash select 1 misses", {30'b0, rs_status}, 32'h0);
      put(1'b0, 1'b0, 5'd5, 20'h00005, mk_w0(1, 0, T2), mk_w1(20'h00555, 0, 1, 2));
      look(2'b10, 32'h0000_5123, T1, 1'b0, 1'b0);
      chk("R2 tag mismatch misses", {30'b0, rs_status}, 32'h0);
      chk("R10 dmiss on store", dmiss_cmp, cmp_of(T1));
      look(2'b01, 32'h0010_5123, T2, 1'b0, 1'b0);
      chk("R2 page mismatch misses", {30'b0, rs_status}, 32'h0);
      look(2'b01, 32'h0000_5123, T2, 1'b0, 1'b0);
      chk("R2 all conditions hit", {30'b0, rs_status}, 32'h1);
      chk("R2 hit raddr", rs_raddr, 32'h0055_5123);
      look(2'b00, 32'h0000_5123, T3, 1'b0, 1'b0);
      chk("R3 fetch does not see data set", {30'b0, rs_status}, 32'h0);
      chk("R10 imiss", imiss_cmp, cmp_of(T3));
      chk("R10 dmiss kept", dmiss_cmp, cmp_of(T2));

      // R3 index sweep over both groups, way 1
      for (int s = 0; s < 32; s++) begin
         put(1'b0, 1'b1, s[4:0], 20'h40000 + s, mk_w0(1, 0, T2), mk_w1(20'h40000 + s, 0, 1, 2));
         put(1'b1, 1'b1, s[4:0], 20'h40000 + s, mk_w0(1, 0, T2), mk_w1(20'h50000 + s, 0, 1, 2));
      end
      for (int s = 0; s < 32; s++) begin
         ea = 32'h4000_0A5C | (s << 12);
         look(2'b01, ea, T2, 1'b0, 1'b0);
         chk("R3 data set raddr", rs_raddr, {20'h40000 + s, 12'hA5C});
         look(2'b00, ea, T2, 1'b0, 1'b0);
         chk("R3 code set raddr", rs_raddr, {20'h50000 + s, 12'hA5C});
      end

      // R5 grant stops the scan
      put(1'b0, 1'b0, 5'd7, 20'h00007, mk_w0(1, 0, T1), mk_w1(20'h00777, 0, 1, 2));
      put(1'b0, 1'b1, 5'd7, 20'h00007, mk_w0(1, 0, T1), mk_w1(20'h00777, 0, 1, 2));
      look(2'b01, 32'h0000_7004, T1, 1'b0, 1'b0);
      chk("R5 granted", {30'b0, rs_status}, 32'h1);
      rdw(1'b0, 1'b0, 5'd7, v); chk("R8 way0 referenced", {31'b0, v[8]}, 32'h1);
      rdw(1'b0, 1'b1, 5'd7, v); chk("R5 way1 untouched", {31'b0, v[8]}, 32'h0);

      // R6 denial continues, last consistent candidate chosen
      put(1'b0, 1'b0, 5'd8, 20'h00008, mk_w0(1, 0, T1), mk_w1(20'h00888, 0, 1, 0));
      put(1'b0, 1'b1, 5'd8, 20'h00008, mk_w0(1, 0, T1), mk_w1(20'h00888, 0, 1, 0));
      look(2'b01, 32'h0000_8010, T1, 1'b1, 1'b0);
      chk("R6 denied", {30'b0, rs_status}, 32'h2);
      chk("R12 denied raddr", rs_raddr, 32'h0088_8010);
      rdw(1'b0, 1'b1, 5'd8, v); chk("R6 way1 referenced", {31'b0, v[8]}, 32'h1);
      rdw(1'b0, 1'b0, 5'd8, v); chk("R6 way0 not referenced", {31'b0, v[8]}, 32'h0);

      // R7 inconsistent later way skipped even though it would grant
      put(1'b0, 1'b0, 5'd10, 20'h0000A, mk_w0(1, 0, T1), mk_w1(20'h00AAA, 0, 1, 0));
      put(1'b0, 1'b1, 5'd10, 20'h0000A, mk_w0(1, 0, T1), mk_w1(20'h00AAB, 0, 1, 2));
      look(2'b01, 32'h0000_A020, T1, 1'b1, 1'b0);
      chk("R7 status", {30'b0, rs_status}, 32'h2);
      chk("R7 raddr from first", rs_raddr, 32'h00AA_A020);
      rdw(1'b0, 1'b0, 5'd10, v); chk("R7 way0 referenced", {31'b0, v[8]}, 32'h1);
      rdw(1'b0, 1'b1, 5'd10, v); chk("R7 way1 untouched", {31'b0, v[8]}, 32'h0);

      // R8/R9 referenced and changed bits
      put(1'b0, 1'b0, 5'd9, 20'h00009, mk_w0(1, 0, T3), mk_w1(20'h00999, 0, 0, 2));
      look(2'b01, 32'h0000_9000, T3, 1'b0, 1'b0);
      chk("R9 clean page drops write", {29'b0, rs_perm}, 32'h5);
      rdw(1'b0, 1'b0, 5'd9, v);
      chk("R8 referenced set", {31'b0, v[8]}, 32'h1);
      chk("R9 changed still clear", {31'b0, v[7]}, 32'h0);
      look(2'b10, 32'h0000_9000, T3, 1'b0, 1'b0);
      chk("R9 store granted", {30'b0, rs_status}, 32'h1);
      chk("R9 store perm", {29'b0, rs_perm}, 32'h7);
      rdw(1'b0, 1'b0, 5'd9, v); chk("R9 changed set", {31'b0, v[7]}, 32'h1);
      look(2'b01, 32'h0000_9000, T3, 1'b0, 1'b0);
      chk("R9 dirty page keeps write", {29'b0, rs_perm}, 32'h7);
      put(1'b0, 1'b0, 5'd11, 20'h0000B, mk_w0(1, 0, T3), mk_w1(20'h00BBB, 0, 0, 1));
      look(2'b10, 32'h0000_B000, T3, 1'b1, 1'b0);
      chk("R9 store denied", {30'b0, rs_status}, 32'h2);
      chk("R9 denied perm", {29'b0, rs_perm}, 32'h5);
      rdw(1'b0, 1'b0, 5'd11, v);
      chk("R8 referenced on denial", {31'b0, v[8]}, 32'h1);
      chk("R9 denied store leaves changed", {31'b0, v[7]}, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule